// File: doc/BRIEF.md
# Dual-Enable Byte-Lane SRAM

This block is a synchronous 16-bit word memory split into two 8-bit lanes, each with its own storage bank. It is selected only by a pair of chip enables of opposite polarity. Active-low write, output and per-lane enables then choose between a word access, a single-byte access and no access. On a read, the data and a per-lane drive flag are registered one clock after the request. Any lane whose drive flag is low is to be treated as high impedance by the pad ring that sits outside this block.

The memory shares its data bus with an external flash device. A monitor raises a conflict flag in every cycle where this block drives a lane while the flash select is also active. System software or a bus arbiter can then catch the contention that the two devices must never create.

Top module: `dual_en_lane_sram`

## Requirements
- R1: The memory is selected only when `ce1_n` is 0 and `ce2` is 1. With any other combination of the two, no write changes the array and no lane is driven in the following cycle.
- R2: A write is committed at the clock edge where the memory is selected, `we_n` is 0 and at least one of `ub_n`/`lb_n` is 0. `ub_n` guards data bits 15..8 and `lb_n` guards bits 7..0. A lane whose enable is 1 keeps its old contents.
- R3: A read is requested when the memory is selected, `we_n` is 1 and `oe_n` is 0. One clock later, `dq_oe` bit 1 (upper lane) and bit 0 (lower lane) are 1 for each lane whose enable was 0, and `dq_out` carries the stored word on those lanes.
- R4: On a read, a lane whose byte enable is 1 has its `dq_oe` bit at 0 and its `dq_out` bits at 0 in the following cycle.
- R5: When `we_n` and `oe_n` are both 1, `dq_oe` is 0 in the following cycle.
- R6: After a deselected cycle, `dq_oe` is 0 in the following cycle.
- R7: `bus_conflict` is 1 in exactly those cycles where some bit of `dq_oe` is 1 and `flash_sel_n` is 0.
- R8: During and right after reset (`rst_n` low), `dq_oe` is 0, `dq_out` is 0 and `bus_conflict` is 0.
- R9: A write cycle takes priority over `oe_n`. When `we_n` is 0 while selected, no lane is driven in the following cycle, even if `oe_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | AW | Word address, AW = clog2(DEPTH) |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| ub_n | input | 1 | Upper lane (bits 15..8) enable, active low |
| lb_n | input | 1 | Lower lane (bits 7..0) enable, active low |
| dq_in | input | 16 | Write data |
| dq_out | output | 16 | Registered read data |
| dq_oe | output | 2 | Per-lane drive flag, bit 1 upper, bit 0 lower; 0 means high impedance |
| flash_sel_n | input | 1 | Select of the other device on the shared bus, active low |
| bus_conflict | output | 1 | Both devices active on the bus |

## Verification
The bench writes with only one lane enabled and then reads the full word. A design that ignores a lane enable on writes corrupts the neighbouring byte, which shows up in that read. It attempts writes under both deselecting combinations of the chip enables, which catches a decoder that looks at only one enable. It requests a read with `oe_n` low during a write cycle and reads with a single lane. A design that gets write priority or lane gating wrong drives a lane that should float. It also drives the flash select both with and without a pending read, so that a monitor that ignores either term raises a false or missing conflict.

// File: rtl/sram_lane_pkg.sv
// Shared constants and types for the dual-enable byte-lane SRAM.
// Assumes two 8-bit lanes; lane 1 is the upper byte.
package sram_lane_pkg;
    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int DATA_W = LANE_W * LANES;

    typedef enum logic [1:0] {
        SRAM_IDLE  = 2'd0,
        SRAM_READ  = 2'd1,
        SRAM_WRITE = 2'd2
    } sram_op_e;

    typedef logic [LANES-1:0] lane_mask_t;
endpackage

// File: rtl/sram_cmd_decode.sv
// Decodes the raw control pins into one operation and a lane mask.
// Assumes the control pins are synchronous to clk. Write wins over read.
module sram_cmd_decode
    import sram_lane_pkg::*;
(
    input  logic       ce1_n,
    input  logic       ce2,
    input  logic       we_n,
    input  logic       oe_n,
    input  logic       ub_n,
    input  logic       lb_n,
    output sram_op_e   op,
    output lane_mask_t lane_en
);
    logic selected;

    // Purpose: chip selection and per-lane enables from the active-low pins.
    always_comb begin
        selected   = ~ce1_n & ce2;
        lane_en[1] = ~ub_n;
        lane_en[0] = ~lb_n;
    end

    // Purpose: pick the operation, giving writes priority over reads.
    always_comb begin
        op = SRAM_IDLE;
        if (selected && !we_n) begin
            if (|lane_en) op = SRAM_WRITE;
        end else if (selected && !oe_n) begin
            op = SRAM_READ;
        end
    end
endmodule

// File: rtl/sram_lane_bank.sv
// One byte lane: storage bank, registered read data and drive flag.
// Assumes storage is uninitialised; only read path registers are reset.
module sram_lane_bank #(
    parameter int DEPTH = 1024,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic          drive
);
    logic [W-1:0] mem [DEPTH];

    // Purpose: commit lane data to the array on an enabled write.
    always_ff @(posedge clk) begin
        if (wr_en) mem[addr] <= wdata;
    end

    // Purpose: register read data and the lane drive flag one cycle after request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            drive <= 1'b0;
        end else if (rd_en) begin
            rdata <= mem[addr];
            drive <= 1'b1;
        end else begin
            rdata <= '0;
            drive <= 1'b0;
        end
    end
endmodule

// File: rtl/sram_bus_guard.sv
// Flags contention between this SRAM driving the bus and an active flash select.
// Assumes flash_sel_n is synchronous to clk.
module sram_bus_guard
    import sram_lane_pkg::*;
(
    input  lane_mask_t drive,
    input  logic       flash_sel_n,
    output logic       conflict
);
    // Purpose: combine any driven lane with the other device's select.
    always_comb conflict = (|drive) & ~flash_sel_n;
endmodule

// File: rtl/dual_en_lane_sram.sv
// Top: 16-bit SRAM with two opposite-polarity chip enables and byte lanes.
// Assumes an external pad ring turns dq_oe into tristate control.
module dual_en_lane_sram
    import sram_lane_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              ub_n,
    input  logic              lb_n,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic [LANES-1:0]  dq_oe,
    input  logic              flash_sel_n,
    output logic              bus_conflict
);
    sram_op_e   op;
    lane_mask_t lane_en;

    sram_cmd_decode u_dec (
        .ce1_n  (ce1_n),
        .ce2    (ce2),
        .we_n   (we_n),
        .oe_n   (oe_n),
        .ub_n   (ub_n),
        .lb_n   (lb_n),
        .op     (op),
        .lane_en(lane_en)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sram_lane_bank #(.DEPTH(DEPTH), .W(LANE_W)) u_bank (
            .clk  (clk),
            .rst_n(rst_n),
            .addr (addr),
            .wr_en((op == SRAM_WRITE) && lane_en[g]),
            .rd_en((op == SRAM_READ) && lane_en[g]),
            .wdata(dq_in[g*LANE_W +: LANE_W]),
            .rdata(dq_out[g*LANE_W +: LANE_W]),
            .drive(dq_oe[g])
        );
    end

    sram_bus_guard u_guard (
        .drive      (dq_oe),
        .flash_sel_n(flash_sel_n),
        .conflict   (bus_conflict)
    );
endmodule

// File: rtl/sram_lane_checker.sv
// Temporal checks on the top-level ports, bound into dual_en_lane_sram.
module sram_lane_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ce1_n,
    input logic       ce2,
    input logic       we_n,
    input logic       oe_n,
    input logic       ub_n,
    input logic       lb_n,
    input logic [1:0] dq_oe,
    input logic       flash_sel_n,
    input logic       bus_conflict
);
    assert_deselect_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ce1_n && ce2) |=> (dq_oe == 2'b00));

    assert_idle_hiz_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we_n && oe_n) |=> (dq_oe == 2'b00));

    assert_write_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce1_n && ce2 && !we_n) |=> (dq_oe == 2'b00));

    assert_upper_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce1_n && ce2 && we_n && !oe_n && ub_n) |=> !dq_oe[1]);

    assert_lower_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce1_n && ce2 && we_n && !oe_n && !lb_n) |=> dq_oe[0]);

    assert_no_conflict_idle_flash_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flash_sel_n |-> !bus_conflict);
endmodule

bind dual_en_lane_sram sram_lane_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce1_n       (ce1_n),
    .ce2         (ce2),
    .we_n        (we_n),
    .oe_n        (oe_n),
    .ub_n        (ub_n),
    .lb_n        (lb_n),
    .dq_oe       (dq_oe),
    .flash_sel_n (flash_sel_n),
    .bus_conflict(bus_conflict)
);

// File: tb/tb_dual_en_lane_sram.sv
`timescale 1ns/1ps
module tb_dual_en_lane_sram;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [9:0]  addr;
    logic        ce1_n, ce2, we_n, oe_n, ub_n, lb_n, flash_sel_n;
    logic [15:0] dq_in;
    logic [15:0] dq_out;
    logic [1:0]  dq_oe;
    logic        bus_conflict;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    dual_en_lane_sram dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce1_n(ce1_n), .ce2(ce2),
        .we_n(we_n), .oe_n(oe_n), .ub_n(ub_n), .lb_n(lb_n), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .flash_sel_n(flash_sel_n),
        .bus_conflict(bus_conflict)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        ce1_n = 1; ce2 = 0; we_n = 1; oe_n = 1; ub_n = 1; lb_n = 1;
        flash_sel_n = 1; dq_in = '0;
    endtask

    task automatic wr(input logic [9:0] a, input logic [15:0] d, input logic u, input logic l,
                      input logic c1 = 0, input logic c2 = 1);
        idle();
        addr = a; dq_in = d; ce1_n = c1; ce2 = c2; we_n = 0; ub_n = u; lb_n = l;
        step();
        idle();
    endtask

    // Issues a read, returns the outputs seen one cycle later.
    task automatic rd(input logic [9:0] a, input logic u, input logic l, input logic fs,
                      output logic [15:0] d, output logic [1:0] oe, output logic cf);
        idle();
        addr = a; ce1_n = 0; ce2 = 1; oe_n = 0; ub_n = u; lb_n = l; flash_sel_n = fs;
        step();
        d = dq_out; oe = dq_oe; cf = bus_conflict;
        idle();
        step();
    endtask

    task automatic t_reset();
        idle(); addr = '0; rst_n = 0;
        step(); step();
        chk("R8 oe", dq_oe, 2'b00);
        chk("R8 data", dq_out, 16'h0);
        chk("R8 conflict", bus_conflict, 1'b0);
        rst_n = 1;
        step();
    endtask

    task automatic t_word();
        logic [15:0] d; logic [1:0] oe; logic cf;
        wr(10'd5, 16'hA55A, 0, 0);
        rd(10'd5, 0, 0, 1, d, oe, cf);
        chk("R3 word data", d, 16'hA55A);
        chk("R3 word oe", oe, 2'b11);
        wr(10'd1023, 16'h1234, 0, 0);
        rd(10'd1023, 0, 0, 1, d, oe, cf);
        chk("R3 top addr data", d, 16'h1234);
    endtask

    task automatic t_byte_write();
        logic [15:0] d; logic [1:0] oe; logic cf;
        wr(10'd7, 16'h1111, 0, 0);
        wr(10'd7, 16'hBEEF, 0, 1);
        rd(10'd7, 0, 0, 1, d, oe, cf);
        chk("R2 upper only", d, 16'hBE11);
        wr(10'd7, 16'hCAFE, 1, 0);
        rd(10'd7, 0, 0, 1, d, oe, cf);
        chk("R2 lower only", d, 16'hBEFE);
        wr(10'd7, 16'h0000, 1, 1);
        rd(10'd7, 0, 0, 1, d, oe, cf);
        chk("R2 no lane", d, 16'hBEFE);
    endtask

    task automatic t_byte_read();
        logic [15:0] d; logic [1:0] oe; logic cf;
        rd(10'd7, 1, 0, 1, d, oe, cf);
        chk("R4 lower read oe", oe, 2'b01);
        chk("R4 lower read data", d, 16'h00FE);
        rd(10'd7, 0, 1, 1, d, oe, cf);
        chk("R4 upper read oe", oe, 2'b10);
        chk("R4 upper read data", d, 16'hBE00);
    endtask

    task automatic t_deselect();
        logic [15:0] d; logic [1:0] oe; logic cf;
        wr(10'd9, 16'h5A5A, 0, 0);
        wr(10'd9, 16'hFFFF, 0, 0, 1, 1);
        wr(10'd9, 16'h0000, 0, 0, 0, 0);
        rd(10'd9, 0, 0, 1, d, oe, cf);
        chk("R1 writes blocked", d, 16'h5A5A);
        idle(); addr = 10'd9; ce1_n = 1; ce2 = 1; oe_n = 0; ub_n = 0; lb_n = 0;
        step();
        chk("R6 ce1_n high oe", dq_oe, 2'b00);
        ce1_n = 0; ce2 = 0;
        step();
        chk("R6 ce2 low oe", dq_oe, 2'b00);
        idle(); step();
    endtask

    task automatic t_idle_hiz();
        idle(); addr = 10'd9; ce1_n = 0; ce2 = 1; ub_n = 0; lb_n = 0;
        step();
        chk("R5 we_n oe_n high", dq_oe, 2'b00);
        idle(); step();
    endtask

    task automatic t_write_priority();
        logic [15:0] d; logic [1:0] oe; logic cf;
        idle(); addr = 10'd11; dq_in = 16'h7E81; ce1_n = 0; ce2 = 1; we_n = 0; oe_n = 0;
        ub_n = 0; lb_n = 0;
        step();
        chk("R9 no drive on write", dq_oe, 2'b00);
        idle(); step();
        rd(10'd11, 0, 0, 1, d, oe, cf);
        chk("R9 write committed", d, 16'h7E81);
    endtask

    task automatic t_conflict();
        logic [15:0] d; logic [1:0] oe; logic cf;
        rd(10'd5, 0, 0, 0, d, oe, cf);
        chk("R7 conflict on read", cf, 1'b1);
        rd(10'd5, 0, 0, 1, d, oe, cf);
        chk("R7 no conflict flash idle", cf, 1'b0);
        idle(); flash_sel_n = 0;
        step();
        chk("R7 no conflict sram idle", bus_conflict, 1'b0);
        idle(); step();
    endtask

    initial begin
        idle(); addr = '0; rst_n = 0;
        t_reset();
        t_word();
        t_byte_write();
        t_byte_read();
        t_deselect();
        t_idle_hiz();
        t_write_priority();
        t_conflict();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule